// File: doc/BRIEF.md
# Cache-Maintenance Effective Address Generator

This block forms the byte address that a cache-maintenance operation acts on. Each request carries a base register value, or a register pair when the wide mode is selected, a signed immediate byte offset, the index of the base register, the number of registers allocated to the issuing thread, a target address space and a constant-bank slot. The block adds base and offset in the width that the mode calls for. It falls back to an absolute address when no usable base register is named, applies the narrower offset of the local window, and places the slot above the offset for the constant space.

The result is registered and leaves one cycle after the request is accepted. It carries the target space and an error flag for request shapes that cannot be honoured. Requests enter and results leave through a valid/ready handshake. A result that is not taken holds the input side closed.

Top module: `cmea_top`

## Requirements
- R1: In narrow mode (in_ext=0) with space data (0) or instruction (2), the address is base_lo + in_imm taken modulo 2^32 and zero-extended, so bits 63:32 of out_addr are zero. An offset of zero yields the base itself.
- R2: In wide mode (in_ext=1) the base is the 64-bit value {in_base_hi, in_base_lo}. in_imm is sign-extended to 64 bits and added to it modulo 2^64.
- R3: When in_base_idx is 255 (the zero register) or in_base_idx >= in_reg_count, the base is not used. The address is then in_imm zero-extended to 64 bits, in both narrow and wide mode.
- R4: In the local space (3) only in_imm[23:0] is used. It is a signed offset when a base is used and is zero-extended when the address is absolute. in_imm[31:24] has no effect.
- R5: In the constant space (1) the address is (in_slot << 16) plus the narrow address of R1/R3, taken modulo 2^32 and zero-extended.
- R6: out_err is 1 and out_addr is 0 when in_ext=1 and either the space is constant or local, or a base is used and in_base_idx is odd, or in_base_idx+1 is 255 or is at or beyond in_reg_count. An absolute wide request in the data space gives no error.
- R7: out_space repeats the request's in_space code: 0 data, 1 constant, 2 instruction, 3 local.
- R8: A request is accepted on a clock edge where in_valid and in_ready are both 1. out_valid is 1 after that edge and falls after an edge where out_ready is 1 and no new request is accepted.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_addr, out_err and out_space hold their values.
- R10: While rst_n is 0, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_space | input | 2 | Target space: 0 data, 1 constant, 2 instruction, 3 local |
| in_ext | input | 1 | Wide (64-bit register pair) mode |
| in_base_idx | input | 8 | Index of the base register; 255 is the zero register |
| in_reg_count | input | 9 | Registers allocated to the thread |
| in_base_lo | input | 32 | Value of the base register |
| in_base_hi | input | 32 | Value of the next register, used in wide mode |
| in_imm | input | 32 | Signed immediate byte offset |
| in_slot | input | 5 | Constant-bank slot |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_addr | output | 64 | Effective byte address |
| out_space | output | 2 | Space of the result |
| out_err | output | 1 | Illegal request shape |

## Verification
The address path is driven with positive and negative offsets, with sums that wrap past 2^32, and with wide sums that carry into or borrow from the high word. A wrong width or a missing sign extension shows up in these cases. Base indices equal to 255, beyond the allocation and just inside it show whether the absolute fallback is chosen correctly. Local requests with junk in the upper immediate bits, constant requests whose slot addition wraps, and wide requests with odd indices or a disallowed space cover the offset rules of each space and the error flag. A stalled output, with a second request waiting behind it, shows that the result holds and the input stays closed until the result is taken.

// File: rtl/cmea_pkg.sv
package cmea_pkg;

   typedef enum logic [1:0] {
      SP_DATA  = 2'd0,
      SP_CONST = 2'd1,
      SP_INSTR = 2'd2,
      SP_LOCAL = 2'd3
   } space_e;

   typedef struct packed {
      space_e space;
      logic   err;
      logic   wide;
   } tag_t;

endpackage

// File: rtl/cmea_base_sel.sv
module cmea_base_sel
   import cmea_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int ZERO_IDX = 255,
   parameter bit WIDE_EN  = 1'b1,
   localparam int CNT_W   = IDX_W + 1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [CNT_W-1:0] count,
   input  logic             ext,
   input  space_e           space,
   output logic             use_base,
   output logic             wide,
   output logic             err
);

   generate
      if (ZERO_IDX >= (1 << IDX_W)) begin : g_bad_zero
         $error("ZERO_IDX does not fit in IDX_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] idx_ext;
   logic [CNT_W-1:0] hi_idx;
   logic             is_zero;
   logic             beyond;
   logic             absolute;
   logic             space_ok;
   logic             pair_bad;
   logic             wide_bad;

   assign idx_ext  = {1'b0, idx};
   assign hi_idx   = idx_ext + CNT_W'(1);
   assign is_zero  = (idx_ext == CNT_W'(ZERO_IDX));
   assign beyond   = (idx_ext >= count);
   assign absolute = is_zero | beyond;
   assign use_base = ~absolute;

   assign space_ok = (space == SP_DATA) | (space == SP_INSTR);
   assign pair_bad = ~absolute &
                     (idx[0] | (hi_idx >= count) | (hi_idx == CNT_W'(ZERO_IDX)));

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_bad = ~space_ok | pair_bad;
      end else begin : g_no_wide
         assign wide_bad = 1'b1;
      end
   endgenerate

   assign err  = ext & wide_bad;
   assign wide = ext & ~wide_bad;

endmodule

// File: rtl/cmea_addr_calc.sv
module cmea_addr_calc
   import cmea_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int LOC_W   = 24,
   parameter int SLOT_W  = 5,
   parameter int SLOT_SH = 16,
   parameter int PHYS_W  = 40,
   parameter int OUT_W   = 64,
   localparam int PAIR_W = 2 * WORD_W
) (
   input  logic [WORD_W-1:0] base_lo,
   input  logic [WORD_W-1:0] base_hi,
   input  logic [WORD_W-1:0] imm,
   input  logic [SLOT_W-1:0] slot,
   input  space_e            space,
   input  logic              use_base,
   input  logic              wide,
   input  logic              err,
   output logic [OUT_W-1:0]  addr
);

   generate
      if (LOC_W > WORD_W) begin : g_bad_loc
         $error("LOC_W must not exceed WORD_W");
      end
      if (SLOT_W + SLOT_SH > WORD_W) begin : g_bad_slot
         $error("slot field overflows the address word");
      end
      if (PHYS_W < WORD_W || PHYS_W > OUT_W) begin : g_bad_phys
         $error("PHYS_W must lie between WORD_W and OUT_W");
      end
      if (PAIR_W != OUT_W) begin : g_bad_pair
         $error("a register pair must fill the output width");
      end
   endgenerate

   logic [WORD_W-1:0] loc_sext;
   logic [WORD_W-1:0] loc_zext;

   generate
      if (LOC_W == WORD_W) begin : g_loc_full
         assign loc_sext = imm;
         assign loc_zext = imm;
      end else begin : g_loc_part
         assign loc_sext = {{(WORD_W-LOC_W){imm[LOC_W-1]}}, imm[LOC_W-1:0]};
         assign loc_zext = {{(WORD_W-LOC_W){1'b0}}, imm[LOC_W-1:0]};
      end
   endgenerate

   logic              is_local;
   logic              is_const;
   logic [WORD_W-1:0] off_word;
   logic [WORD_W-1:0] abs_word;
   logic [WORD_W-1:0] narrow_word;
   logic [WORD_W-1:0] slot_word;
   logic [WORD_W-1:0] final_word;
   logic [PHYS_W-1:0] phys_addr;
   logic [OUT_W-1:0]  narrow_out;
   logic [PAIR_W-1:0] pair_base;
   logic [PAIR_W-1:0] pair_off;
   logic [PAIR_W-1:0] wide_sum;

   assign is_local = (space == SP_LOCAL);
   assign is_const = (space == SP_CONST);

   assign off_word    = is_local ? loc_sext : imm;
   assign abs_word    = is_local ? loc_zext : imm;
   assign narrow_word = use_base ? (base_lo + off_word) : abs_word;
   assign slot_word   = WORD_W'({{(WORD_W-SLOT_W){1'b0}}, slot} << SLOT_SH);
   assign final_word  = is_const ? (narrow_word + slot_word) : narrow_word;

   assign phys_addr  = {{(PHYS_W-WORD_W){1'b0}}, final_word};

   generate
      if (PHYS_W == OUT_W) begin : g_phys_full
         assign narrow_out = phys_addr;
      end else begin : g_phys_part
         assign narrow_out = {{(OUT_W-PHYS_W){1'b0}}, phys_addr};
      end
   endgenerate

   assign pair_base = {base_hi, base_lo};
   assign pair_off  = {{WORD_W{imm[WORD_W-1]}}, imm};
   assign wide_sum  = use_base ? (pair_base + pair_off)
                               : {{WORD_W{1'b0}}, imm};

   always_comb begin
      if (err) begin
         addr = '0;
      end else if (wide) begin
         addr = wide_sum;
      end else begin
         addr = narrow_out;
      end
   end

endmodule

// File: rtl/cmea_out_reg.sv
module cmea_out_reg
   import cmea_pkg::*;
#(
   parameter int OUT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OUT_W-1:0] in_addr,
   input  tag_t             in_tag,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_addr,
   output tag_t             out_tag
);

   logic take;

   assign in_ready = ~out_valid | out_ready;
   assign take     = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_tag   <= '{space: SP_DATA, err: 1'b0, wide: 1'b0};
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_addr  <= in_addr;
            out_tag   <= in_tag;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R8

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag))); // R9

endmodule

// File: rtl/cmea_top.sv
module cmea_top
   import cmea_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int IDX_W    = 8,
   parameter int ZERO_IDX = 255,
   parameter int LOC_W    = 24,
   parameter int SLOT_W   = 5,
   parameter int SLOT_SH  = 16,
   parameter int PHYS_W   = 40,
   parameter bit WIDE_EN  = 1'b1,
   localparam int OUT_W   = 2 * WORD_W,
   localparam int CNT_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_space,
   input  logic              in_ext,
   input  logic [IDX_W-1:0]  in_base_idx,
   input  logic [CNT_W-1:0]  in_reg_count,
   input  logic [WORD_W-1:0] in_base_lo,
   input  logic [WORD_W-1:0] in_base_hi,
   input  logic [WORD_W-1:0] in_imm,
   input  logic [SLOT_W-1:0] in_slot,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_addr,
   output logic [1:0]        out_space,
   output logic              out_err
);

   space_e           space;
   logic             use_base;
   logic             wide;
   logic             err;
   logic [OUT_W-1:0] addr;
   tag_t             tag_d;
   tag_t             tag_q;

   assign space = space_e'(in_space);

   cmea_base_sel #(
      .IDX_W    (IDX_W),
      .ZERO_IDX (ZERO_IDX),
      .WIDE_EN  (WIDE_EN)
   ) u_base_sel (
      .idx      (in_base_idx),
      .count    (in_reg_count),
      .ext      (in_ext),
      .space    (space),
      .use_base (use_base),
      .wide     (wide),
      .err      (err)
   );

   cmea_addr_calc #(
      .WORD_W  (WORD_W),
      .LOC_W   (LOC_W),
      .SLOT_W  (SLOT_W),
      .SLOT_SH (SLOT_SH),
      .PHYS_W  (PHYS_W),
      .OUT_W   (OUT_W)
   ) u_addr_calc (
      .base_lo  (in_base_lo),
      .base_hi  (in_base_hi),
      .imm      (in_imm),
      .slot     (in_slot),
      .space    (space),
      .use_base (use_base),
      .wide     (wide),
      .err      (err),
      .addr     (addr)
   );

   assign tag_d = '{space: space, err: err, wide: wide};

   cmea_out_reg #(
      .OUT_W (OUT_W)
   ) u_out_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_addr   (addr),
      .in_tag    (tag_d),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_addr  (out_addr),
      .out_tag   (tag_q)
   );

   assign out_space = tag_q.space;
   assign out_err   = tag_q.err;

   AST_NARROW_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !tag_q.wide) |-> (out_addr[OUT_W-1:WORD_W] == '0)); // R1

   AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_addr == '0)); // R6

   AST_ERR_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_ext) |=> !out_err); // R6

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && in_ready)); // R10

endmodule

// File: tb/tb_cmea_top.sv
module tb_cmea_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 5000;
   localparam int NV         = 19;

   typedef struct packed {
      logic [1:0]  sp;
      logic        ext;
      logic [7:0]  idx;
      logic [8:0]  cnt;
      logic [31:0] lo;
      logic [31:0] hi;
      logic [31:0] imm;
      logic [4:0]  slot;
      logic [63:0] exp_addr;
      logic        exp_err;
      logic [3:0]  rq;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      // R1 plain sum
      '{2'd0, 1'b0, 8'd4,   9'd32, 32'h0000_1000, 32'h0, 32'h0000_0010, 5'd0,  64'h0000_1010, 1'b0, 4'd1},
      // R1 wrap past 2^32
      '{2'd0, 1'b0, 8'd4,   9'd32, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 5'd0,  64'h0000_0010, 1'b0, 4'd1},
      // R1 negative offset
      '{2'd0, 1'b0, 8'd4,   9'd32, 32'h0000_0100, 32'h0, 32'hFFFF_FFF0, 5'd0,  64'h0000_00F0, 1'b0, 4'd1},
      // R1 zero offset
      '{2'd0, 1'b0, 8'd4,   9'd32, 32'h0000_1234, 32'h0, 32'h0,         5'd0,  64'h0000_1234, 1'b0, 4'd1},
      // R2 carry into high word
      '{2'd0, 1'b1, 8'd6,   9'd32, 32'hFFFF_FFF0, 32'h1, 32'h0000_0020, 5'd0,  64'h2_0000_0010, 1'b0, 4'd2},
      // R2 borrow from high word
      '{2'd0, 1'b1, 8'd6,   9'd32, 32'h0,         32'h2, 32'hFFFF_FFFF, 5'd0,  64'h1_FFFF_FFFF, 1'b0, 4'd2},
      // R3 zero register
      '{2'd0, 1'b0, 8'd255, 9'd256,32'h0000_DEAD, 32'h0, 32'h0000_0080, 5'd0,  64'h0000_0080, 1'b0, 4'd3},
      // R3 index beyond allocation
      '{2'd0, 1'b0, 8'd40,  9'd32, 32'h0000_0005, 32'h0, 32'hFFFF_FFFF, 5'd0,  64'hFFFF_FFFF, 1'b0, 4'd3},
      // R3 wide absolute
      '{2'd0, 1'b1, 8'd255, 9'd32, 32'h0000_0009, 32'h7, 32'hFFFF_FFFF, 5'd0,  64'hFFFF_FFFF, 1'b0, 4'd3},
      // R4 local signed 24-bit offset, junk above
      '{2'd3, 1'b0, 8'd2,   9'd32, 32'h0000_0200, 32'h0, 32'hABFF_FFFF, 5'd0,  64'h0000_01FF, 1'b0, 4'd4},
      // R4 local absolute, zero-extended 24 bits
      '{2'd3, 1'b0, 8'd255, 9'd32, 32'h0000_0200, 32'h0, 32'hAB80_0000, 5'd0,  64'h0080_0000, 1'b0, 4'd4},
      // R5 constant with base
      '{2'd1, 1'b0, 8'd2,   9'd32, 32'h0000_0040, 32'h0, 32'h0000_0004, 5'd3,  64'h0003_0044, 1'b0, 4'd5},
      // R5 constant absolute
      '{2'd1, 1'b0, 8'd255, 9'd32, 32'h0000_0040, 32'h0, 32'h0000_0010, 5'h1F, 64'h001F_0010, 1'b0, 4'd5},
      // R5 constant wrap
      '{2'd1, 1'b0, 8'd2,   9'd32, 32'hFFF0_0000, 32'h0, 32'h0,         5'h1F, 64'h000F_0000, 1'b0, 4'd5},
      // R6 odd pair start
      '{2'd0, 1'b1, 8'd5,   9'd32, 32'h0000_1000, 32'h1, 32'h0000_0010, 5'd0,  64'h0,          1'b1, 4'd6},
      // R6 wide constant
      '{2'd1, 1'b1, 8'd2,   9'd32, 32'h0000_1000, 32'h1, 32'h0000_0010, 5'd1,  64'h0,          1'b1, 4'd6},
      // R6 high register beyond allocation
      '{2'd0, 1'b1, 8'd30,  9'd31, 32'h0000_1000, 32'h1, 32'h0000_0010, 5'd0,  64'h0,          1'b1, 4'd6},
      // R6 wide local
      '{2'd3, 1'b1, 8'd2,   9'd32, 32'h0000_1000, 32'h1, 32'h0000_0010, 5'd0,  64'h0,          1'b1, 4'd6},
      // R7 instruction space
      '{2'd2, 1'b0, 8'd8,   9'd32, 32'h0000_0800, 32'h0, 32'h0000_0004, 5'd0,  64'h0000_0804, 1'b0, 4'd7}
   };

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [1:0]  in_space;
   logic        in_ext;
   logic [7:0]  in_base_idx;
   logic [8:0]  in_reg_count;
   logic [31:0] in_base_lo;
   logic [31:0] in_base_hi;
   logic [31:0] in_imm;
   logic [4:0]  in_slot;
   logic        out_valid;
   logic        out_ready;
   logic [63:0] out_addr;
   logic [1:0]  out_space;
   logic        out_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   cmea_top dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_space     (in_space),
      .in_ext       (in_ext),
      .in_base_idx  (in_base_idx),
      .in_reg_count (in_reg_count),
      .in_base_lo   (in_base_lo),
      .in_base_hi   (in_base_hi),
      .in_imm       (in_imm),
      .in_slot      (in_slot),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_addr     (out_addr),
      .out_space    (out_space),
      .out_err      (out_err)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_space     = v.sp;
      in_ext       = v.ext;
      in_base_idx  = v.idx;
      in_reg_count = v.cnt;
      in_base_lo   = v.lo;
      in_base_hi   = v.hi;
      in_imm       = v.imm;
      in_slot      = v.slot;
   endtask

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      out_ready = 1'b1;
      drive(VECS[0]);
      repeat (2) @(negedge clk);
      // R10 reset state
      check("R10 out_valid", 64'(out_valid), 64'd0);
      check("R10 in_ready", 64'(in_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         in_valid  = 1'b1;
         out_ready = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check($sformatf("R8 valid vec%0d", i), 64'(out_valid), 64'd1);
         check($sformatf("R%0d addr vec%0d", VECS[i].rq, i), out_addr, VECS[i].exp_addr);
         check($sformatf("R6 err vec%0d", i), 64'(out_err), 64'(VECS[i].exp_err));
         check($sformatf("R7 space vec%0d", i), 64'(out_space), 64'(VECS[i].sp));
      end

      @(negedge clk);
      // R8 drains when taken and nothing new arrives
      check("R8 drained", 64'(out_valid), 64'd0);

      // R9 stall with a second request waiting
      drive(VECS[0]);
      in_valid  = 1'b1;
      out_ready = 1'b0;
      @(negedge clk);
      drive(VECS[18]);
      check("R9 in_ready low", 64'(in_ready), 64'd0);
      @(negedge clk);
      check("R9 held valid", 64'(out_valid), 64'd1);
      check("R9 held addr", out_addr, 64'h0000_1010);
      check("R9 held space", 64'(out_space), 64'd0);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 waiting request taken", out_addr, 64'h0000_0804);
      check("R7 waiting request space", 64'(out_space), 64'd2);
      @(negedge clk);
      check("R8 fall after take", 64'(out_valid), 64'd0);

      // R10 reset mid-stream
      drive(VECS[1]);
      in_valid  = 1'b1;
      out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      #1;
      check("R10 reset clears valid", 64'(out_valid), 64'd0);
      check("R10 reset opens input", 64'(in_ready), 64'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule